// File: doc/BRIEF.md
# Sample-Hold-Evaluate Conversion Sequencer

This block produces the digital control timing for one conversion of a flash converter built from slow mechanical switches. A conversion drives a sampling control, a holding control, a comparator precharge control and an evaluation control in a fixed order. A one-cycle strobe then tells the downstream decoder that the comparator outputs are settled and can be captured. The switch closing delay and opening delay are given as clock-cycle counts on two input buses. They are captured when a conversion launches and stay fixed for that conversion.

Each control that follows another rises early by the closing delay minus the opening delay. The new switch therefore finishes closing at the moment the old one finishes opening. This overlap shortens a conversion when closing is the slower action. Consecutive conversions are spaced by at least twice the sum of both delays. This spacing is what a pair of complementary switches needs. A request that arrives too early is remembered and served at the first legal cycle.

Top module: `shed_seq`

## Requirements
Notation: the delays captured at launch are N (closing delay) and F (opening delay). The lead is L = N−F when N > F, else 0. Let A = N+1, H = A−L, E = H+A−L and T = E+N+1. The cycle in which `smp` is first high is t = 0.
- R1: A synchronous active-high `rst` forces all six outputs low from the next cycle, returns the block to idle, and discards any remembered request.
- R2: A `go` seen by a clock edge while the block is idle makes `smp` and `busy` high in the cycle after that edge. N and F are taken from `ton` and `toff` at that edge. Later changes on `ton` and `toff` do not alter the conversion in progress.
- R3: `smp` is high for cycles 0 to A−1.
- R4: `hld` is high for cycles H to H+A−1, so it rises L cycles before `smp` falls.
- R5: `pchg` is high for cycles H to E−1 and is never high in the same cycle as `evl`.
- R6: `evl` is high for cycles E to T−1, so it rises L cycles before `hld` falls.
- R7: `done` is high for exactly one cycle, cycle E+N, which is the last cycle of `evl`. `busy` is high for cycles 0 to T−1 only.
- R8: The next conversion cannot begin before cycle P = max(T, 2·(N+F)) of the current one.
- R9: A `go` seen at an edge that ends any cycle before P−1 is remembered; a conversion then begins at cycle P. Several such requests merge into one conversion.
- R10: A `go` seen at the edge ending cycle P−1 begins the next conversion at cycle P directly. A `go` after the block has gone idle begins a conversion in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Conversion request |
| ton | input | DW | Switch closing delay in cycles |
| toff | input | DW | Switch opening delay in cycles |
| smp | output | 1 | Sampling switch control |
| hld | output | 1 | Holding switch control |
| pchg | output | 1 | Comparator precharge and reset control |
| evl | output | 1 | Comparator evaluation control |
| done | output | 1 | One-cycle capture strobe for the decoder |
| busy | output | 1 | High while a conversion runs |

## Verification
The done strobe and the acceptance of a new request can fall in the same cycle. This happens when the conversion end and the minimum period coincide, for example with equal delays of 3 cycles, where both T and P equal 12. The bench raises a request in exactly the done cycle (cycle 11). It judges the result by requiring the strobe to appear as usual and `smp` to rise again in the very next cycle. The bench also raises requests in earlier cycles, where the request must wait for the period. It raises requests after idle, where the new conversion must start one cycle later.

// File: rtl/shed_seq.sv
module shed_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] ton,
  input  logic [DW-1:0] toff,
  output logic          smp,
  output logic          hld,
  output logic          pchg,
  output logic          evl,
  output logic          done,
  output logic          busy
);
  localparam int CW = DW + 3;

  logic [DW-1:0] on_q, off_q, lead_q;
  logic [CW-1:0] cnt;
  logic          run, pend;

  logic [CW-1:0] a_w, h_w, e_w, d_w, t_w, p_w, lim_w;
  logic          can_go, launch;

  assign a_w   = CW'(on_q) + CW'(1);
  assign h_w   = a_w - CW'(lead_q);
  assign e_w   = h_w + a_w - CW'(lead_q);
  assign d_w   = e_w + CW'(on_q);
  assign t_w   = d_w + CW'(1);
  assign p_w   = (CW'(on_q) + CW'(off_q)) << 1;
  assign lim_w = (t_w > p_w) ? t_w : p_w;

  assign can_go = !run || (cnt == lim_w - CW'(1));
  assign launch = (go || pend) && can_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      pend   <= 1'b0;
      cnt    <= '0;
      on_q   <= '0;
      off_q  <= '0;
      lead_q <= '0;
    end else if (launch) begin
      run    <= 1'b1;
      pend   <= 1'b0;
      cnt    <= '0;
      on_q   <= ton;
      off_q  <= toff;
      lead_q <= (ton > toff) ? ton - toff : '0;
    end else begin
      if (go) pend <= 1'b1;
      if (run) begin
        if (cnt == lim_w - CW'(1)) run <= 1'b0;
        else cnt <= cnt + CW'(1);
      end
    end
  end

  assign smp  = run && (cnt < a_w);
  assign hld  = run && (cnt >= h_w) && (cnt < h_w + a_w);
  assign pchg = run && (cnt >= h_w) && (cnt < e_w);
  assign evl  = run && (cnt >= e_w) && (cnt < t_w);
  assign done = run && (cnt == d_w);
  assign busy = run && (cnt < t_w);
endmodule

module shed_seq_chk (
  input logic clk,
  input logic rst,
  input logic smp,
  input logic hld,
  input logic pchg,
  input logic evl,
  input logic done,
  input logic busy
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !(smp || hld || pchg || evl || done || busy));

  // R5
  pchg_evl_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pchg && evl));

  // R6
  evl_after_pchg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evl) |-> $past(pchg));

  // R4
  hld_after_smp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hld) |-> (smp || $past(smp)));

  // R2
  smp_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(smp) |-> (!hld && !evl && !pchg && busy));

  // R7
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (evl && busy));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !evl));
endmodule

bind shed_seq shed_seq_chk u_shed_seq_chk (
  .clk(clk), .rst(rst), .smp(smp), .hld(hld),
  .pchg(pchg), .evl(evl), .done(done), .busy(busy)
);

// File: tb/test_shed_seq.sv
module test_shed_seq;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst, go;
  logic [7:0] ton, toff;
  logic smp, hld, pchg, evl, done, busy;
  int tests = 0, fails = 0;
  bit finished = 0;

  shed_seq i_shed_seq (
    .clk(clk), .rst(rst), .go(go), .ton(ton), .toff(toff),
    .smp(smp), .hld(hld), .pchg(pchg), .evl(evl), .done(done), .busy(busy)
  );

  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [5:0] expv(int n, int f, int t);
    int a, ld, h, e, tt;
    a  = n + 1;
    ld = (n > f) ? n - f : 0;
    h  = a - ld;
    e  = h + a - ld;
    tt = e + n + 1;
    if (t < 0) return 6'b0;
    return {t < a, (t >= h) && (t < h + a), (t >= h) && (t < e),
            (t >= e) && (t < tt), t == e + n, t < tt};
  endfunction

  function automatic int limv(int n, int f);
    int a, ld, tt;
    a  = n + 1;
    ld = (n > f) ? n - f : 0;
    tt = 2 * (a - ld) + n + 1;
    return (tt > 2 * (n + f)) ? tt : 2 * (n + f);
  endfunction

  task automatic chk(logic [5:0] e, string req, int t);
    logic [5:0] act;
    act = {smp, hld, pchg, evl, done, busy};
    tests++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s t=%0d actual=%b expected=%b (smp hld pchg evl done busy)",
               req, t, act, e);
    end
  endtask

  task automatic launch(int n, int f);
    ton  = 8'(n);
    toff = 8'(f);
    go   = 1'b1;
    @(negedge clk);
    go   = 1'b0;
  endtask

  // R3 R4 R5 R6 R7: single conversion profile
  task automatic t_single(int n, int f, string req);
    launch(n, f);
    for (int t = 0; t <= limv(n, f) + 1; t++) begin
      chk(expv(n, f, t), req, t);
      @(negedge clk);
    end
  endtask

  // R8 R9 R10: request during or after a conversion
  task automatic t_pulse(int n, int f, int p, int w, string req);
    int l, l2;
    l  = limv(n, f);
    l2 = (p + 1 > l) ? p + 1 : l;
    launch(n, f);
    for (int t = 0; t <= l2 + limv(n, f) + 1; t++) begin
      chk((t < l2) ? expv(n, f, t) : expv(n, f, t - l2), req, t);
      go = (t >= p) && (t < p + w);
      @(negedge clk);
    end
    go = 1'b0;
  endtask

  // R2: delay inputs captured at launch
  task automatic t_latch();
    launch(5, 2);
    for (int t = 0; t <= limv(5, 2) + 1; t++) begin
      chk(expv(5, 2, t), "R2", t);
      if (t == 1) begin
        ton  = 8'd9;
        toff = 8'd1;
      end
      @(negedge clk);
    end
  endtask

  // R1: reset mid-conversion clears pending request
  task automatic t_reset_mid();
    launch(5, 2);
    for (int t = 0; t <= 30; t++) begin
      chk((t <= 3) ? expv(5, 2, t) : 6'b0, "R1", t);
      go  = (t == 2);
      rst = (t == 3);
      @(negedge clk);
    end
    go  = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; go = 1'b0; ton = 8'd0; toff = 8'd0;
    repeat (3) @(negedge clk);
    chk(6'b0, "R1", -1);
    rst = 1'b0;
    @(negedge clk);
    chk(6'b0, "R1", -1);
    t_single(5, 2, "R4");
    t_single(3, 3, "R6");
    t_single(2, 6, "R5");
    t_single(0, 4, "R3");
    t_single(10, 0, "R7");
    t_latch();
    t_pulse(5, 2, 4, 3, "R9");
    t_pulse(5, 2, 13, 1, "R10");
    t_pulse(3, 3, 11, 1, "R10");
    t_pulse(2, 6, 20, 1, "R8");
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule